// File: doc/BRIEF.md
# Addressed Three-Wire Configuration Slave

This block is the configuration port of one sensor channel on a shared three-wire serial bus made of a select line, a serial clock and a bidirectional data line. Up to eight channels share the bus. Each channel reads a 3-bit strap value, and a frame acts on a channel only when the address bits in the frame equal that strap value. A frame opens when select rises and closes when select falls. Its first bit chooses read or write. The next three bits carry the address, and four ignored bits follow.

A three-state output-control input sets what a frame means. When the control is driven low or left floating, a 16-clock frame either loads an 8-bit analog adjustment register or reads it back. When the control is driven high, a short 8-clock frame selects which channel may drive the shared analog output. A frame with the wrong number of clocks is rejected. The block samples the serial lines with its own system clock and treats the serial clock's edges as events. It drives a separate enable for the data pin's tri-state buffer.

Top module: `cfg_slave`

## Requirements
- R1: After reset the adjustment register is 0x00, the output-select flag is clear, and the data pin drive enable `sdo_oe_o` is low.
- R2: When the output control is low or floating at the rise of select, a frame with exactly 16 rising serial clocks, first bit 0 and address bits equal to `strap_i` loads frame bits 9 to 16 into `cfg_o`. Bit 9 goes to `cfg_o[7]`. The load happens on the fall of select, and the four bits that follow the address have no effect.
- R3: A write frame whose address bits differ from `strap_i` leaves `cfg_o` unchanged.
- R4: A write frame with 15 or 17 clocks leaves `cfg_o` unchanged. So does any clock count other than 16.
- R5: When the output control is low or floating, a frame with first bit 1 and a matching address asserts `sdo_oe_o` from the 8th falling serial clock until select falls. It drives `cfg_o[7]` after the 8th falling clock and `cfg_o[7-i]` after falling clock 8+i, so `cfg_o[0]` follows the 15th.
- R6: A read frame with a mismatching address never asserts `sdo_oe_o`. Whenever select is low, `sdo_oe_o` is low from the next system clock on.
- R7: When the output control is high at the rise of select, a frame with exactly 8 clocks, first bit 0 and a matching address sets the output-select flag on the fall of select. Any other frame clears the flag: a mismatching address, a first bit of 1, or a clock count other than 8. Such frames never change `cfg_o`, and several may follow one another.
- R8: `out_en_o` is 0 when `oe_low_i` is 1, which takes priority. It is 1 when neither `oe_low_i` nor `oe_high_i` is set (floating). It follows the output-select flag when only `oe_high_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Serial select; high marks a frame |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data from the bus |
| sdo_o | output | 1 | Serial read data toward the bus |
| sdo_oe_o | output | 1 | Drive enable for the data pin buffer |
| strap_i | input | 3 | Strap address of this channel |
| oe_high_i | input | 1 | Output control driven high |
| oe_low_i | input | 1 | Output control driven low |
| cfg_o | output | 8 | Analog adjustment register |
| out_en_o | output | 1 | Analog output enable |

## Verification
The bench builds the block with its default parameters: three address bits, four ignored bits and an 8-bit register. These give the 8-clock select frame and the 16-clock full frame. The strap is tied to 101, so mismatching frames can differ from it in a single address bit. One frame builder covers clock counts of 7, 9, 15 and 17 as well as the legal lengths. It also runs a 16-clock write while the output control is high, which must clear the select flag and leave the register alone.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;

  typedef enum logic [1:0] {
    OE_DRIVEN_LOW  = 2'd0,
    OE_FLOATING    = 2'd1,
    OE_DRIVEN_HIGH = 2'd2
  } oe_state_e;

  // low wins when both are set
  function automatic oe_state_e oe_decode(input logic hi, input logic lo);
    if (lo)      return OE_DRIVEN_LOW;
    else if (hi) return OE_DRIVEN_HIGH;
    else         return OE_FLOATING;
  endfunction

endpackage

// File: rtl/cfg_slave_edge.sv
module cfg_slave_edge #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= in_i;
  end

  assign lvl_o  = q;
  assign rise_o = in_i & ~q;
  assign fall_o = ~in_i & q;
endmodule

// File: rtl/cfg_slave_rx.sv
module cfg_slave_rx #(
  parameter int LEN   = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [LEN-1:0]   shreg_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LEN-1:0]   sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q <= {sh_q[LEN-2:0], bit_i};
      // saturate so overlong frames never wrap to a legal length
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign shreg_o = sh_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/cfg_slave_tx.sv
module cfg_slave_tx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stop_i,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] data_i,
  output logic         sdo_o,
  output logic         sdo_oe_o
);
  logic [W-1:0] tx_q;
  logic         act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      act_q <= 1'b0;
    end else if (stop_i) begin
      tx_q  <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      tx_q  <= data_i;
      act_q <= 1'b1;
    end else if (adv_i && act_q) begin
      tx_q <= {tx_q[W-2:0], 1'b0};
    end
  end

  assign sdo_o    = tx_q[W-1];
  assign sdo_oe_o = act_q;
endmodule

// File: rtl/cfg_slave.sv
module cfg_slave
  import cfg_slave_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DUMMY_W = 4,
  parameter int CFG_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [ADDR_W-1:0] strap_i,
  input  logic              oe_high_i,
  input  logic              oe_low_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              out_en_o
);
  localparam int SHORT_LEN = 1 + ADDR_W + DUMMY_W;
  localparam int FULL_LEN  = SHORT_LEN + CFG_W;
  localparam int CNT_W     = $clog2(FULL_LEN + 2);
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_LEN);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FULL_LEN);

  logic [1:0] lvl, rise, fall;
  logic       sel_q, sel_rise, sel_fall, sck_rise, sck_fall;

  cfg_slave_edge #(.W(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({sel_i, sck_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sel_q    = lvl[1];
  assign sel_rise = rise[1];
  assign sel_fall = fall[1];
  assign sck_rise = rise[0] & sel_q & sel_i;
  assign sck_fall = fall[0] & sel_q & sel_i;

  logic [FULL_LEN-1:0] shreg;
  logic [CNT_W-1:0]    cnt;

  cfg_slave_rx #(.LEN(FULL_LEN), .CNT_W(CNT_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (sel_rise),
    .shift_i (sck_rise),
    .bit_i   (sdi_i),
    .shreg_o (shreg),
    .cnt_o   (cnt)
  );

  // frame fields as seen after a short or a full frame
  logic              rw_short, rw_full;
  logic [ADDR_W-1:0] addr_short, addr_full;
  assign rw_short   = shreg[SHORT_LEN-1];
  assign addr_short = shreg[SHORT_LEN-2 -: ADDR_W];
  assign rw_full    = shreg[FULL_LEN-1];
  assign addr_full  = shreg[FULL_LEN-2 -: ADDR_W];

  oe_state_e mode_q;
  logic [CFG_W-1:0] cfg_q;
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= OE_FLOATING;
    else if (sel_rise) mode_q <= oe_decode(oe_high_i, oe_low_i);
  end

  logic short_ok, full_wr_ok;
  assign short_ok   = (cnt == SHORT_CNT) && !rw_short && (addr_short == strap_i);
  assign full_wr_ok = (cnt == FULL_CNT) && !rw_full && (addr_full == strap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      gate_q <= 1'b0;
    end else if (sel_fall) begin
      if (mode_q == OE_DRIVEN_HIGH) gate_q <= short_ok;
      else if (full_wr_ok)          cfg_q  <= shreg[CFG_W-1:0];
    end
  end

  // read hit decided on the falling clock that ends the header
  logic rd_hit;
  assign rd_hit = sck_fall && (cnt == SHORT_CNT) && (mode_q != OE_DRIVEN_HIGH)
                  && rw_short && (addr_short == strap_i);

  cfg_slave_tx #(.W(CFG_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stop_i   (sel_fall | sel_rise | ~sel_i),
    .load_i   (rd_hit),
    .adv_i    (sck_fall),
    .data_i   (cfg_q),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  always_comb begin
    unique case (oe_decode(oe_high_i, oe_low_i))
      OE_DRIVEN_LOW:  out_en_o = 1'b0;
      OE_DRIVEN_HIGH: out_en_o = gate_q;
      default:        out_en_o = 1'b1;
    endcase
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cfg_slave_chk.sv
module cfg_slave_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             sdo_oe_o,
  input logic             oe_high_i,
  input logic             oe_low_i,
  input logic             out_en_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             gate_q
);
  AST_DRIVE_ONLY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !sdo_oe_o) else $error("drive outside frame"); // R6

  AST_CFG_AT_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o != $past(cfg_o)) |-> !$past(sel_i)) else $error("cfg changed mid frame"); // R2

  AST_GATE_AT_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q != $past(gate_q)) |-> !$past(sel_i)) else $error("gate changed mid frame"); // R7

  AST_LOW_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_low_i |-> !out_en_o) else $error("output on with control low"); // R8

  AST_FLOAT_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_low_i && !oe_high_i) |-> out_en_o) else $error("output off while floating"); // R8
endmodule

bind cfg_slave cfg_slave_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .sdo_oe_o  (sdo_oe_o),
  .oe_high_i (oe_high_i),
  .oe_low_i  (oe_low_i),
  .out_en_o  (out_en_o),
  .cfg_o     (cfg_o),
  .gate_q    (gate_q)
);

// File: tb/cfg_slave_tb.sv
module cfg_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic oe_hi = 1'b0, oe_lo = 1'b0;
  logic sdo, sdo_oe, out_en;
  logic [7:0] cfg;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .strap_i(STRAP),
    .oe_high_i(oe_hi), .oe_low_i(oe_lo), .cfg_o(cfg), .out_en_o(out_en)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic rw, input logic [2:0] a, input logic [7:0] d);
    return {rw, a, 4'b1010, d};
  endfunction

  task automatic frame(input logic [15:0] bits, input int nclk,
                       output logic [7:0] rd, output int drv);
    rd = 8'h00; drv = 0;
    sel = 1'b1; idle(HALF);
    for (int k = 0; k < nclk; k++) begin
      sdi = (k < 16) ? bits[15-k] : 1'b0;
      idle(HALF);
      if (k >= 8 && k < 16) begin
        rd[15-k] = sdo;
        drv += int'(sdo_oe);
      end
      sck = 1'b1; idle(HALF);
      sck = 1'b0;
    end
    idle(HALF);
    sel = 1'b0; sdi = 1'b0;
    idle(HALF);
  endtask

  task automatic t_reset;
    chk("R1 cfg after reset", cfg, 8'h00);
    chk("R1 drive enable after reset", {7'd0, sdo_oe}, 8'h00);
    chk("R8 floating enables", {7'd0, out_en}, 8'h01);
  endtask

  task automatic t_write;
    logic [7:0] rd; int drv;
    oe_lo = 1'b1; idle(2);
    chk("R8 low disables", {7'd0, out_en}, 8'h00);
    frame(mk(1'b0, STRAP, 8'hA5), 16, rd, drv);
    chk("R2 write with control low", cfg, 8'hA5);
    oe_lo = 1'b0; idle(2);
    frame(mk(1'b0, STRAP, 8'h3C), 16, rd, drv);
    chk("R2 write with control floating", cfg, 8'h3C);
    frame({1'b0, STRAP, 4'b0101, 8'hC3}, 16, rd, drv);
    chk("R2 ignored bits have no effect", cfg, 8'hC3);
  endtask

  task automatic t_write_miss;
    logic [7:0] rd; int drv;
    frame(mk(1'b0, 3'b100, 8'h11), 16, rd, drv);
    chk("R3 mismatched address ignored", cfg, 8'hC3);
    frame(mk(1'b0, 3'b001, 8'h22), 16, rd, drv);
    chk("R3 mismatched address ignored", cfg, 8'hC3);
  endtask

  task automatic t_bad_len;
    logic [7:0] rd; int drv;
    frame(mk(1'b0, STRAP, 8'h77), 15, rd, drv);
    chk("R4 15 clocks rejected", cfg, 8'hC3);
    frame(mk(1'b0, STRAP, 8'h77), 17, rd, drv);
    chk("R4 17 clocks rejected", cfg, 8'hC3);
    frame(mk(1'b0, STRAP, 8'h77), 8, rd, drv);
    chk("R4 8 clocks rejected", cfg, 8'hC3);
  endtask

  task automatic t_read;
    logic [7:0] rd; int drv;
    frame(mk(1'b1, STRAP, 8'h00), 16, rd, drv);
    chk("R5 read data", rd, 8'hC3);
    chk("R5 drive enable on each read bit", 8'(drv), 8'd8);
    chk("R6 drive released after select falls", {7'd0, sdo_oe}, 8'h00);
    frame(mk(1'b0, STRAP, 8'h5A), 16, rd, drv);
    frame(mk(1'b1, STRAP, 8'h00), 16, rd, drv);
    chk("R5 read back after new write", rd, 8'h5A);
    chk("R2 read leaves register", cfg, 8'h5A);
  endtask

  task automatic t_read_miss;
    logic [7:0] rd; int drv;
    frame(mk(1'b1, 3'b111, 8'h00), 16, rd, drv);
    chk("R6 mismatched read not driven", 8'(drv), 8'd0);
    frame(mk(1'b0, STRAP, 8'h5A), 16, rd, drv);
    chk("R6 write frame not driven", 8'(drv), 8'd0);
  endtask

  task automatic t_select;
    logic [7:0] rd; int drv;
    oe_hi = 1'b1; idle(2);
    chk("R8 high follows clear flag", {7'd0, out_en}, 8'h00);
    frame(mk(1'b0, STRAP, 8'h00), 8, rd, drv);
    chk("R7 matching select enables", {7'd0, out_en}, 8'h01);
    frame(mk(1'b0, STRAP, 8'h99), 16, rd, drv);
    chk("R7 16 clocks under high disables", {7'd0, out_en}, 8'h00);
    chk("R7 register untouched under high", cfg, 8'h5A);
    frame(mk(1'b0, STRAP, 8'h00), 8, rd, drv);
    frame(mk(1'b0, 3'b100, 8'h00), 8, rd, drv);
    chk("R7 mismatch disables", {7'd0, out_en}, 8'h00);
    frame(mk(1'b0, 3'b100, 8'h00), 8, rd, drv);
    chk("R7 mismatch keeps disabled", {7'd0, out_en}, 8'h00);
    frame(mk(1'b0, STRAP, 8'h00), 8, rd, drv);
    chk("R7 back-to-back select enables", {7'd0, out_en}, 8'h01);
    frame(mk(1'b1, STRAP, 8'h00), 8, rd, drv);
    chk("R7 read bit disables", {7'd0, out_en}, 8'h00);
    chk("R6 no drive under high", 8'(drv), 8'd0);
    frame(mk(1'b0, STRAP, 8'h00), 8, rd, drv);
    frame(mk(1'b0, STRAP, 8'h00), 7, rd, drv);
    chk("R7 7 clocks disables", {7'd0, out_en}, 8'h00);
    frame(mk(1'b0, STRAP, 8'h00), 8, rd, drv);
    frame(mk(1'b0, STRAP, 8'h00), 9, rd, drv);
    chk("R7 9 clocks disables", {7'd0, out_en}, 8'h00);
    frame(mk(1'b0, STRAP, 8'h00), 8, rd, drv);
    oe_lo = 1'b1; idle(2);
    chk("R8 low overrides set flag", {7'd0, out_en}, 8'h00);
    oe_lo = 1'b0; idle(2);
    chk("R8 high follows set flag", {7'd0, out_en}, 8'h01);
    oe_hi = 1'b0; idle(2);
    chk("R8 floating enables", {7'd0, out_en}, 8'h01);
    chk("R7 register kept", cfg, 8'h5A);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_write();
    t_write_miss();
    t_bad_len();
    t_read();
    t_read_miss();
    t_select();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule